// File: doc/BRIEF.md
# Programmable Memory Chip-Select and Wait-State Generator

This block watches a 24-bit memory address and a memory-request strobe and produces active-low chip selects for three memory regions: lower, middle and upper. The lower region is not fixed by a comparator. It is the set of addresses in which every address bit that software picks through a mask reads zero. The middle region is an inclusive range on the top address byte. The upper region starts at a programmable base. Every select is registered, so it appears in the cycle after the edge that samples the address.

When a select asserts at the start of an access, the block can hold the bus for a programmed number of extra cycles through a ready output. Each region has its own count of 0 to 3 cycles. A mode bit splits the middle select into four sub-selects, one for each value of address bits 17..16, and each sub-select has its own wait count. During refresh cycles only the lower select may fire, and only when software has enabled it.

Top module: `csel_wait_gen`

## Requirements
- R1: After reset all selects are high, `rdy` is high, every mask bit and wait count is zero and refresh selection is off. With this setting the lower region matches every address.
- R2: Write address 0 stores mask bits for A15..A12 in data bits 7..4 and the refresh enable in data bit 0. Write address 1 stores mask bits for A23..A16 in data bits 7..0. The lower region matches only when every address bit whose mask bit is 1 is zero. With all twelve mask bits set it covers 0x000000..0x000FFF.
- R3: In a cycle with `mreq` and `rfsh` both high, `lcs_n` goes low only if the refresh enable is 1 and the address is in the lower region, and it then uses the lower wait count. The middle and upper selects stay high in refresh cycles.
- R4: Write addresses 2 and 3 set the inclusive low and high bounds of the middle region, compared against A23..A16.
- R5: Write address 4 sets the upper base. The upper region is every address with A23..A16 at or above that base.
- R6: Priority is lower, then middle, then upper. At most one select output is low at any time.
- R7: While `mreq` is low, every select goes high on the next clock.
- R8: Write address 5 holds the wait counts for lower in bits 1..0, middle in bits 3..2 and upper in bits 5..4. On the clock at which `mreq` first rises, the selected region's count N is loaded. `rdy` is then low for exactly N cycles, counted from the cycle in which the select appears, and high afterwards. N = 0 inserts no wait. Dropping `mreq` ends the wait.
- R9: An access that selects no region inserts no wait.
- R10: Bit 7 of write address 5 selects six-select mode. In that mode the middle select is `mcs_n[i]`, where i = A17..A16, and its wait count is bits 2i+1..2i of write address 6. In three-select mode only `mcs_n[0]` is used, and it takes the middle wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| mreq | input | 1 | Memory request, active high |
| rfsh | input | 1 | Refresh cycle indicator, active high |
| addr | input | 24 | Memory address |
| lcs_n | output | 1 | Lower region select, active low |
| mcs_n | output | 4 | Middle selects, active low (only bit 0 in three-select mode) |
| ucs_n | output | 1 | Upper region select, active low |
| rdy | output | 1 | Low while wait cycles are being inserted |

## Verification
The hardest case to reach is the one where several decode paths overlap. That means an address that satisfies the lower mask and also lies in the middle range, or a middle address that also sits above the upper base. A refresh cycle whose address falls outside the lower region is the same kind of case. To reach these, the stimulus rewrites the mask and bound registers between access groups so that regions overlap on purpose. It also repeats refresh cycles with the enable both cleared and set. Wait timing is checked by holding `mreq` across several cycles and observing `rdy` in each one, after an idle cycle has re-armed the start detection.

// File: rtl/csw_pkg.sv
package csw_pkg;
    parameter int ADDR_W    = 24;
    parameter int HI_LSB    = 16;
    parameter int LMASK_LSB = 12;
    parameter int WAIT_W    = 2;
    parameter int SUB_LSB   = 16;
    parameter int N_SUB     = 4;
    localparam int HI_W     = ADDR_W - HI_LSB;
    localparam int LMASK_W  = ADDR_W - LMASK_LSB;
    localparam int SUB_W    = $clog2(N_SUB);
    localparam int CS_W     = N_SUB + 2;

    typedef struct packed {
        logic [LMASK_W-1:0]      lmask;
        logic                    rfsh_en;
        logic [HI_W-1:0]         mid_lo;
        logic [HI_W-1:0]         mid_hi;
        logic [HI_W-1:0]         up_base;
        logic                    six_mode;
        logic [WAIT_W-1:0]       w_low;
        logic [WAIT_W-1:0]       w_mid;
        logic [WAIT_W-1:0]       w_up;
        logic [N_SUB*WAIT_W-1:0] w_sub;
    } cfg_t;

    typedef struct packed {
        logic              mreq_prev;
        logic [WAIT_W-1:0] cnt;
        logic [CS_W-1:0]   cs_n;
    } bus_state_t;
endpackage

// File: rtl/csw_regs.sv
module csw_regs
    import csw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] waddr,
    input  logic [7:0] wdata,
    output cfg_t       cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (waddr)
                3'd0: begin
                    cfg_d.lmask[3:0] = wdata[7:4];
                    cfg_d.rfsh_en    = wdata[0];
                end
                3'd1: cfg_d.lmask[LMASK_W-1:4] = wdata;
                3'd2: cfg_d.mid_lo  = wdata;
                3'd3: cfg_d.mid_hi  = wdata;
                3'd4: cfg_d.up_base = wdata;
                3'd5: begin
                    cfg_d.w_low    = wdata[1:0];
                    cfg_d.w_mid    = wdata[3:2];
                    cfg_d.w_up     = wdata[5:4];
                    cfg_d.six_mode = wdata[7];
                end
                3'd6: cfg_d.w_sub = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (cfg_q == '0));
endmodule

// File: rtl/csw_decode.sv
module csw_decode
    import csw_pkg::*;
(
    input  cfg_t               cfg,
    input  logic               mreq,
    input  logic               rfsh,
    input  logic [ADDR_W-1:0]  addr,
    output logic               sel_low,
    output logic [N_SUB-1:0]   sel_mid,
    output logic               sel_up,
    output logic [WAIT_W-1:0]  wsel
);
    logic [HI_W-1:0]  hi;
    logic [SUB_W-1:0] idx;
    logic             low_hit, mid_hit, up_hit;

    always_comb begin
        hi      = addr[ADDR_W-1:HI_LSB];
        idx     = addr[SUB_LSB+SUB_W-1:SUB_LSB];
        low_hit = ((addr[ADDR_W-1:LMASK_LSB] & cfg.lmask) == '0);
        mid_hit = (hi >= cfg.mid_lo) && (hi <= cfg.mid_hi);
        up_hit  = (hi >= cfg.up_base);
        sel_low = 1'b0;
        sel_mid = '0;
        sel_up  = 1'b0;
        wsel    = '0;
        if (mreq) begin
            if (rfsh) begin
                if (cfg.rfsh_en && low_hit) begin
                    sel_low = 1'b1;
                    wsel    = cfg.w_low;
                end
            end else if (low_hit) begin
                sel_low = 1'b1;
                wsel    = cfg.w_low;
            end else if (mid_hit) begin
                if (cfg.six_mode) begin
                    sel_mid[idx] = 1'b1;
                    wsel = cfg.w_sub[int'(idx)*WAIT_W +: WAIT_W];
                end else begin
                    sel_mid[0] = 1'b1;
                    wsel = cfg.w_mid;
                end
            end else if (up_hit) begin
                sel_up = 1'b1;
                wsel   = cfg.w_up;
            end
        end
    end

    // R6
    decode_onehot_chk: assert final ($countones({sel_low, sel_mid, sel_up}) <= 1);
endmodule

// File: rtl/csel_wait_gen.sv
module csel_wait_gen
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              mreq,
    input  logic              rfsh,
    input  logic [ADDR_W-1:0] addr,
    output logic              lcs_n,
    output logic [N_SUB-1:0]  mcs_n,
    output logic              ucs_n,
    output logic              rdy
);
    cfg_t              cfg;
    logic              sel_low, sel_up;
    logic [N_SUB-1:0]  sel_mid;
    logic [WAIT_W-1:0] wsel;
    bus_state_t        st_d, st_q;

    csw_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    csw_decode u_dec (
        .cfg     (cfg),
        .mreq    (mreq),
        .rfsh    (rfsh),
        .addr    (addr),
        .sel_low (sel_low),
        .sel_mid (sel_mid),
        .sel_up  (sel_up),
        .wsel    (wsel)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mreq_prev = mreq;
        st_d.cs_n      = ~{sel_up, sel_mid, sel_low};
        if (!mreq)                  st_d.cnt = '0;
        else if (!st_q.mreq_prev)   st_d.cnt = wsel;
        else if (st_q.cnt != '0)    st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mreq_prev: 1'b0, cnt: '0, cs_n: '1};
        else        st_q <= st_d;
    end

    assign lcs_n = st_q.cs_n[0];
    assign mcs_n = st_q.cs_n[N_SUB:1];
    assign ucs_n = st_q.cs_n[N_SUB+1];
    assign rdy   = (st_q.cnt == '0);

    // R6
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{ucs_n, mcs_n, lcs_n}) <= 1);
    // R7
    idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq |=> (lcs_n && ucs_n && (&mcs_n)));
    // R3
    rfsh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && rfsh && !cfg.rfsh_en) |=> (lcs_n && ucs_n && (&mcs_n)));
    // R8
    wait_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && st_q.mreq_prev && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    // R10
    three_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.six_mode |=> (&mcs_n[N_SUB-1:1]));
endmodule

// File: tb/csel_wait_gen_bench.sv
module csel_wait_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        mreq = 1'b0;
    logic        rfsh = 1'b0;
    logic [23:0] addr = '0;
    logic        lcs_n, ucs_n, rdy;
    logic [3:0]  mcs_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [5:0] NONE = 6'h3F, SL = 6'h3E, M0 = 6'h3D, M1 = 6'h3B,
                           M2 = 6'h37, M3 = 6'h2F, SU = 6'h1F;

    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    csel_wait_gen u_csel_wait_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mreq(mreq), .rfsh(rfsh), .addr(addr),
        .lcs_n(lcs_n), .mcs_n(mcs_n), .ucs_n(ucs_n), .rdy(rdy)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // expected: select vector {ucs, mcs[3:0], lcs} and rdy after the next edge
    task automatic step(input logic m, input logic r, input logic [23:0] a,
                        input logic [5:0] cs, input logic rd, input string tag);
        @(negedge clk);
        mreq = m; rfsh = r; addr = a;
        exp_q.push_back({cs, rd});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 24'h0, NONE, 1'b1, "R7");
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [6:0] e;
            logic [6:0] got;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {ucs_n, mcs_n, lcs_n, rdy};
            n_run++;
            if (got !== e) begin
                n_fail++;
                $display("FAIL %s: got cs=%b rdy=%b expected cs=%b rdy=%b",
                         t, got[6:1], got[0], e[6:1], e[0]);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if ({ucs_n, mcs_n, lcs_n, rdy} !== 7'h7F) begin
            n_fail++;
            $display("FAIL R1: got %b expected %b", {ucs_n, mcs_n, lcs_n, rdy}, 7'h7F);
        end
        // R1: default lower covers everything
        step(1, 0, 24'hABCDEF, SL, 1, "R1");
        idle();
        step(1, 0, 24'hFFFFFF, SL, 1, "R1");
        idle();
        // configure: 4 KB lower, middle 0x10..0x7F, upper >= 0x80, waits 1/2/3
        wr(3'd0, 8'hF0);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h10);
        wr(3'd3, 8'h7F);
        wr(3'd4, 8'h80);
        wr(3'd5, 8'h39);
        idle();
        step(1, 0, 24'h000FFF, SL, 0, "R2");
        step(1, 0, 24'h000FFF, SL, 1, "R8");
        idle();
        step(1, 0, 24'h001000, NONE, 1, "R9");
        idle();
        step(1, 0, 24'h200000, M0, 0, "R4");
        step(1, 0, 24'h200000, M0, 0, "R8");
        step(1, 0, 24'h200000, M0, 1, "R8");
        idle();
        step(1, 0, 24'h7FFFFF, M0, 0, "R4");
        idle();
        step(1, 0, 24'h0FFFFF, NONE, 1, "R4");
        idle();
        step(1, 0, 24'h900000, SU, 0, "R5");
        step(1, 0, 24'h900000, SU, 0, "R8");
        step(1, 0, 24'h900000, SU, 0, "R8");
        step(1, 0, 24'h900000, SU, 1, "R8");
        idle();
        // R8: dropping mreq ends wait
        step(1, 0, 24'h900000, SU, 0, "R8");
        idle();
        // R3: refresh disabled
        step(1, 1, 24'h000100, NONE, 1, "R3");
        idle();
        wr(3'd0, 8'hF1);
        idle();
        step(1, 1, 24'h000100, SL, 0, "R3");
        step(1, 1, 24'h000100, SL, 1, "R3");
        idle();
        step(1, 1, 24'h200000, NONE, 1, "R3");
        idle();
        // R6: middle beats upper
        wr(3'd4, 8'h20);
        idle();
        step(1, 0, 24'h300000, M0, 0, "R6");
        idle();
        // R10: six-select mode
        wr(3'd5, 8'hB9);
        wr(3'd6, 8'hE4);
        idle();
        step(1, 0, 24'h300000, M0, 1, "R10");
        idle();
        step(1, 0, 24'h310000, M1, 0, "R10");
        step(1, 0, 24'h310000, M1, 1, "R10");
        idle();
        step(1, 0, 24'h220000, M2, 0, "R10");
        step(1, 0, 24'h220000, M2, 0, "R10");
        step(1, 0, 24'h220000, M2, 1, "R10");
        idle();
        step(1, 0, 24'h230000, M3, 0, "R10");
        step(1, 0, 24'h230000, M3, 0, "R10");
        step(1, 0, 24'h230000, M3, 0, "R10");
        step(1, 0, 24'h230000, M3, 1, "R10");
        idle();
        // R2/R6: mask only A23, lower wins over middle
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h80);
        idle();
        step(1, 0, 24'h7FFFFF, SL, 0, "R6");
        idle();
        step(1, 0, 24'h800000, SU, 0, "R2");
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule